// File: doc/BRIEF.md
# Push-Button Hold-Time Classifier

This block watches one active-low push-button line and sorts every press into one of three outcomes by how long the button stays down. A short press and a medium press are decided when the button is let go. Each one sets its own sticky status bit, and that bit can raise an interrupt. A very long hold is decided while the button is still down. It skips the status and interrupt path entirely and emits a one-cycle system-reset pulse together with a force-off request.

All timing is counted in pulses of a 1 ms strobe input (`tick_ms`). A bench or a faster system can therefore shorten every threshold by driving a faster strobe or by overriding the parameters. The raw input first passes a two-flop synchronizer and then a debounce filter. Only after that does the hold timer see it.

The timer is a three-state machine:
- **IDLE**: the button is up.
  - Transition *press-seen* goes to TIMING and clears the counter.
- **TIMING**: the counter advances once per tick.
  - Transition *release* goes back to IDLE and classifies the press.
  - Transition *long-reached* fires the reset and off pulse and goes to LOCKED.
- **LOCKED**: the long action has fired.
  - Transition *release-after-long* goes back to IDLE with no event.

A small register port selects the medium threshold, enables the interrupts, and reads or clears the status bits.

Top module: `btn_hold_classifier`

## Requirements
- R1: After reset:
  - both status bits read 0;
  - the control register reads 0;
  - `irq`, `sys_rst` and `force_off` are low.
- R2: A change on `btn_n` is accepted only after it differs from the filtered state on DB_TICKS consecutive ticks. A glitch that lasts fewer ticks produces no event.
- R3: A press released after more than SHORT_MIN ticks, and before the medium threshold, sets status bit 0 (short) at address 0.
- R4: A press released at or below SHORT_MIN ticks sets no status bit.
- R5: A press released at or after the medium threshold sets status bit 1 (medium) at address 0, and does not set bit 0.
- R6: Control bits [1:0] at address 1 select the medium threshold as (2 + value) × MED_UNIT ticks. The codes 00, 01, 10 and 11 give 2, 3, 4 and 5 units.
- R7: When the hold count reaches LONG_TICKS while the button is still down:
  - `sys_rst` and `force_off` each pulse high for exactly one cycle, once per press;
  - releasing afterwards sets no status bit.
- R8: Writing to address 0 with a data bit at 1 clears that status bit, and a data bit at 0 leaves it unchanged. If a set event and a clear fall in the same cycle, the set wins.
- R9: `irq` is high when status bit 0 is set with control bit 2 (short enable) set, or when status bit 1 is set with control bit 3 (medium enable) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle timing strobe, nominally every 1 ms |
| btn_n | input | 1 | Raw push-button line, low when pressed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 status, 1 control |
| wr_data | input | 4 | Write data |
| rd_addr | input | 1 | Read address: 0 status, 1 control |
| rd_data | output | 4 | Read data: status in [1:0], or control in [3:0] |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse on a long hold |
| force_off | output | 1 | One-cycle force-off request on a long hold |

## Verification
A classified release can set a status bit in the same cycle that software writes 1 to clear that same bit.

The bench provokes this directly. It holds a write-1 to the short bit on every cycle across the whole release window of a short press, and it samples the status once per cycle. With set-over-clear priority, the bit must be seen high in exactly one sampled cycle before the following write clears it. A design that lets the clear win never shows the bit at all.

// File: rtl/btn_hold_pkg.sv
package btn_hold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_LOCKED = 2'd2
    } hold_state_t;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_CTRL   = 1'b1;

    localparam int STAT_W = 2;
    localparam int CTRL_W = 4;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int DB_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic pressed
);
    localparam int CW = $clog2(DB_TICKS + 1);

    logic          sync1, sync2;
    logic          raw_press;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= btn_n;
            sync2 <= sync1;
        end
    end

    assign raw_press = ~sync2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            pressed <= 1'b0;
        end else if (raw_press == pressed) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (run_cnt == CW'(DB_TICKS - 1)) begin
                pressed <= raw_press;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pressed)); // R2

endmodule

// File: rtl/btn_hold_fsm.sv
module btn_hold_fsm
    import btn_hold_pkg::*;
#(
    parameter int SHORT_MIN  = 100,
    parameter int MED_UNIT   = 1000,
    parameter int LONG_TICKS = 15000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pressed,
    input  logic [1:0] med_sel,
    output logic       short_pulse,
    output logic       med_pulse,
    output logic       long_pulse
);
    localparam int CW = $clog2(LONG_TICKS + 1);

    hold_state_t   state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;
    logic [31:0]   med_limit;
    logic          go_short, go_med, go_long;

    assign med_limit = (32'(med_sel) + 32'd2) * 32'(MED_UNIT);

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        go_short  = 1'b0;
        go_med    = 1'b0;
        go_long   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pressed) begin
                    nxt_state = ST_TIMING;
                    nxt_cnt   = '0;
                end
            end
            ST_TIMING: begin
                if (!pressed) begin
                    nxt_state = ST_IDLE;
                    if (32'(cnt) >= med_limit) begin
                        go_med = 1'b1;
                    end else if (32'(cnt) > 32'(SHORT_MIN)) begin
                        go_short = 1'b1;
                    end
                end else if (tick) begin
                    if (32'(cnt) + 32'd1 == 32'(LONG_TICKS)) begin
                        go_long   = 1'b1;
                        nxt_state = ST_LOCKED;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (!pressed) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_pulse <= 1'b0;
            med_pulse   <= 1'b0;
            long_pulse  <= 1'b0;
        end else begin
            short_pulse <= go_short;
            med_pulse   <= go_med;
            long_pulse  <= go_long;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({short_pulse, med_pulse, long_pulse})); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < 32'(LONG_TICKS)); // R7
    AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        long_pulse |=> !long_pulse); // R7
    AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |=> (!short_pulse && !med_pulse)); // R7

endmodule

// File: rtl/btn_status_regs.sv
module btn_status_regs
    import btn_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_evt,
    input  logic              med_evt,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [CTRL_W-1:0] rd_data,
    output logic [1:0]        med_sel,
    output logic              irq
);
    logic [STAT_W-1:0] status;
    logic [CTRL_W-1:0] ctrl;
    logic [STAT_W-1:0] set_vec, clr_vec;
    logic              stat_wr;

    assign stat_wr = wr_en && (wr_addr == ADDR_STATUS);
    assign set_vec = {med_evt, short_evt};
    assign clr_vec = stat_wr ? wr_data[STAT_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            ctrl   <= '0;
        end else begin
            status <= set_vec | (status & ~clr_vec);
            if (wr_en && (wr_addr == ADDR_CTRL)) ctrl <= wr_data;
        end
    end

    assign med_sel = ctrl[1:0];
    assign irq     = |(status & ctrl[3:2]);
    assign rd_data = (rd_addr == ADDR_CTRL) ? ctrl : {{(CTRL_W-STAT_W){1'b0}}, status};

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        short_evt |=> status[0]); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_data[0] && !short_evt) |=> !status[0]); // R8
    AST_MED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(stat_wr && wr_data[1])) |=> status[1]); // R5

endmodule

// File: rtl/btn_hold_classifier.sv
module btn_hold_classifier #(
    parameter int DB_TICKS   = 10,
    parameter int SHORT_MIN  = 100,
    parameter int MED_UNIT   = 1000,
    parameter int LONG_TICKS = 15000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       btn_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [3:0] wr_data,
    input  logic       rd_addr,
    output logic [3:0] rd_data,
    output logic       irq,
    output logic       sys_rst,
    output logic       force_off
);
    logic       pressed;
    logic       short_pulse, med_pulse, long_pulse;
    logic [1:0] med_sel;

    btn_debounce #(.DB_TICKS(DB_TICKS)) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .btn_n   (btn_n),
        .pressed (pressed)
    );

    btn_hold_fsm #(
        .SHORT_MIN  (SHORT_MIN),
        .MED_UNIT   (MED_UNIT),
        .LONG_TICKS (LONG_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_ms),
        .pressed     (pressed),
        .med_sel     (med_sel),
        .short_pulse (short_pulse),
        .med_pulse   (med_pulse),
        .long_pulse  (long_pulse)
    );

    btn_status_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_evt (short_pulse),
        .med_evt   (med_pulse),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .med_sel   (med_sel),
        .irq       (irq)
    );

    assign sys_rst   = long_pulse;
    assign force_off = long_pulse;

    AST_LONG_NO_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        long_pulse |-> (!short_pulse && !med_pulse)); // R7

endmodule

// File: tb/btn_hold_classifier_bench.sv
module btn_hold_classifier_bench;
    localparam int DB   = 3;
    localparam int SMIN = 10;
    localparam int UNIT = 50;
    localparam int LONG = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       btn_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       rd_addr = 1'b0;
    logic [3:0] rd_data;
    logic       irq, sys_rst, force_off;

    int checks = 0;
    int fails  = 0;
    int n_rst  = 0;
    int n_off  = 0;
    int tick_div = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    btn_hold_classifier #(
        .DB_TICKS(DB), .SHORT_MIN(SMIN), .MED_UNIT(UNIT), .LONG_TICKS(LONG)
    ) u_btn_hold_classifier (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst), .force_off(force_off)
    );

    always @(negedge clk) begin
        tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
        tick_ms  <= (tick_div == 3);
    end

    always @(posedge clk) begin
        if (sys_rst)   n_rst <= n_rst + 1;
        if (force_off) n_off <= n_off + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic a, output logic [3:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic hold_ticks(input int n);
        @(negedge clk);
        btn_n = 1'b0;
        repeat (n * 4) @(negedge clk);
        btn_n = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic clear_all();
        reg_wr(1'b0, 4'b0011);
    endtask

    task automatic t_reset();
        logic [3:0] v;
        reg_rd(1'b0, v); chk(v == 4'd0, "R1 status", int'(v), 0);
        reg_rd(1'b1, v); chk(v == 4'd0, "R1 ctrl", int'(v), 0);
        chk({irq, sys_rst, force_off} == 3'b000, "R1 outputs", int'({irq, sys_rst, force_off}), 0);
    endtask

    task automatic t_glitch();
        logic [3:0] v;
        @(negedge clk); btn_n = 1'b0;
        repeat (8) @(negedge clk); btn_n = 1'b1;
        repeat (40) @(negedge clk);
        reg_rd(1'b0, v); chk(v == 4'd0, "R2 glitch ignored", int'(v), 0);
    endtask

    task automatic t_too_short();
        logic [3:0] v;
        hold_ticks(6);
        reg_rd(1'b0, v); chk(v == 4'd0, "R4 below short min", int'(v), 0);
    endtask

    task automatic t_short();
        logic [3:0] v;
        hold_ticks(30);
        reg_rd(1'b0, v); chk(v == 4'b0001, "R3 short press", int'(v), 1);
        reg_wr(1'b0, 4'b0000);
        reg_rd(1'b0, v); chk(v == 4'b0001, "R8 write 0 keeps", int'(v), 1);
        clear_all();
        reg_rd(1'b0, v); chk(v == 4'b0000, "R8 write 1 clears", int'(v), 0);
    endtask

    task automatic t_medium_sel0();
        logic [3:0] v;
        reg_wr(1'b1, 4'b0000);
        hold_ticks(130);
        reg_rd(1'b0, v); chk(v == 4'b0010, "R5 medium at 2 units", int'(v), 2);
        clear_all();
        hold_ticks(80);
        reg_rd(1'b0, v); chk(v == 4'b0001, "R6 below 2 units is short", int'(v), 1);
        clear_all();
    endtask

    task automatic t_medium_sel3();
        logic [3:0] v;
        reg_wr(1'b1, 4'b0011);
        reg_rd(1'b1, v); chk(v == 4'b0011, "R6 ctrl readback", int'(v), 3);
        hold_ticks(200);
        reg_rd(1'b0, v); chk(v == 4'b0001, "R6 sel 11 200 ticks short", int'(v), 1);
        clear_all();
        hold_ticks(280);
        reg_rd(1'b0, v); chk(v == 4'b0010, "R6 sel 11 280 ticks medium", int'(v), 2);
        clear_all();
    endtask

    task automatic t_irq();
        logic [3:0] v;
        reg_wr(1'b1, 4'b1000);
        hold_ticks(30);
        reg_rd(1'b0, v);
        chk(v == 4'b0001 && irq == 1'b0, "R9 short masked", int'(irq), 0);
        hold_ticks(130);
        chk(irq == 1'b1, "R9 medium enabled", int'(irq), 1);
        reg_wr(1'b0, 4'b0010);
        chk(irq == 1'b0, "R9 cleared drops irq", int'(irq), 0);
        reg_wr(1'b1, 4'b1100);
        chk(irq == 1'b1, "R9 short enabled", int'(irq), 1);
        clear_all();
        reg_wr(1'b1, 4'b0000);
    endtask

    task automatic t_long();
        logic [3:0] v;
        int r0;
        int o0;
        r0 = n_rst;
        o0 = n_off;
        @(negedge clk); btn_n = 1'b0;
        repeat (650 * 4) @(negedge clk);
        chk(n_rst - r0 == 1, "R7 reset pulse while held", n_rst - r0, 1);
        chk(n_off - o0 == 1, "R7 force-off pulse while held", n_off - o0, 1);
        repeat (100 * 4) @(negedge clk);
        btn_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(n_rst - r0 == 1, "R7 single reset pulse", n_rst - r0, 1);
        reg_rd(1'b0, v); chk(v == 4'd0, "R7 no status after long", int'(v), 0);
        chk(irq == 1'b0, "R7 no irq after long", int'(irq), 0);
    endtask

    task automatic t_set_vs_clear();
        int highs;
        highs = 0;
        @(negedge clk); btn_n = 1'b0;
        repeat (30 * 4) @(negedge clk);
        btn_n = 1'b1;
        rd_addr = 1'b0;
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 4'b0001;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #1 if (rd_data[0]) highs++;
        end
        wr_en = 1'b0; wr_data = 4'd0;
        chk(highs == 1, "R8 set wins over clear", highs, 1);
        clear_all();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_glitch();
        t_too_short();
        t_short();
        t_medium_sel0();
        t_medium_sel3();
        t_irq();
        t_set_vs_clear();
        t_long();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule